// File: doc/BRIEF.md
# UART transmitter with CTS hold-off

This block turns parallel characters into an asynchronous serial stream on a single transmit line. Each bit period is counted in pulses of a 16x oversampling enable (`tick16`), which an external baud divisor supplies. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional even or odd parity bit, and then a high stop period. The stop period lasts one bit, one and a half bits, or two bits.

A character is handed over with a valid/ready handshake. The frame settings are captured when the character is accepted, so software may change them while a frame is on the line. A break control holds the line low for as long as it is set. An automatic flow-control mode stops the next start bit while the clear-to-send input is low. A frame that has already started always runs to its end. The transmit FIFO and the baud divisor are outside this block.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset `txd` is 1, `tx_empty` is 1, and `tx_ready` is 1 while `cfg_flow_en` is 0.
- R2: A character is accepted on a clock edge where `chr_valid` and `tx_ready` are both 1. From the next cycle `tx_empty` and `tx_ready` are 0 until the frame ends. The word length, parity and stop settings are taken at acceptance, and later changes to them have no effect on that frame.
- R3: The start bit drives `txd` to 0. It begins in the cycle after acceptance and lasts 16 ticks.
- R4: `cfg_wlen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The bits go out least significant first, 16 ticks each. Bits of `chr_data` above the selected length are ignored.
- R5: When `cfg_par_en` is 1, one parity bit of 16 ticks follows the data. With `cfg_par_odd` = 0 the count of ones in data plus parity is even, and with `cfg_par_odd` = 1 it is odd.
- R6: The stop period holds `txd` at 1. It lasts 16 ticks when `cfg_stop_long` is 0. When `cfg_stop_long` is 1 it lasts 24 ticks for 5-bit characters and 32 ticks for any other length. `tx_empty` returns to 1 on the tick that ends the stop period.
- R7: While `cfg_break` is 1, `txd` is 0, whether the block is idle or sending. The frame timing continues underneath.
- R8: When `cfg_flow_en` is 1 and `cts` is 0, `tx_ready` is 0 and no character starts. `cts` passes through a synchroniser of SYNC_STAGES flops, so `tx_ready` follows `cts` after SYNC_STAGES cycles. When `cfg_flow_en` is 0, `cts` is ignored.
- R9: A frame in progress completes with the normal timing if `cts` goes low partway through. Only the next start bit is held back.
- R10: The frame advances only in cycles where `tick16` is 1. Between ticks, `txd` and `tx_empty` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at 16 times the baud rate |
| chr_data | input | DATA_W | Character to send, right aligned |
| chr_valid | input | 1 | Character offered |
| cfg_wlen | input | 2 | Data bits: 0 to 3 select 5 to 8 |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop_long | input | 1 | 1 selects the long stop period (1.5 or 2 bits) |
| cfg_break | input | 1 | Force the line low |
| cfg_flow_en | input | 1 | Enable CTS hold-off of new characters |
| cts | input | 1 | Clear to send, asynchronous, 1 means clear |
| tx_ready | output | 1 | A character can be accepted this cycle |
| tx_empty | output | 1 | No frame in progress |
| txd | output | 1 | Serial output, idles at 1 |

## Verification
Some rules are checked by assertions on every cycle: the break level and the idle-high level, the handshake (the block goes busy right after acceptance and leaves idle only through acceptance), the low start bit, stability between ticks, and the CTS hold-off measured against the checker's own history of `cts`. Other behaviour can only be shown by the bench scenarios, which compare the line tick by tick against a computed frame. These are the data order and masking for each length, both parity senses, the 16, 24 and 32 tick stop periods, the capture of settings at acceptance, and a frame that finishes after `cts` drops partway through.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } txf_state_e;

   // number of data bits for a 2-bit length code (0..3 -> 5..8)
   function automatic int unsigned txf_bits(input logic [1:0] code);
      return 32'd5 + {30'd0, code};
   endfunction

endpackage

// File: rtl/uart_txf_cts_sync.sv
module uart_txf_cts_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_out = async_in;
      end else begin : g_chain
         logic [STAGES-1:0] ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q[0] <= 1'b0;
            else        ff_q[0] <= async_in;
         end
         for (genvar k = 1; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) ff_q[k] <= 1'b0;
               else        ff_q[k] <= ff_q[k-1];
            end
         end
         assign sync_out = ff_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/uart_txf_framer.sv
module uart_txf_framer
   import uart_txf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        wlen,
   input  logic              par_odd,
   output logic [DATA_W-1:0] payload,
   output logic              parity
);

   // zero every bit at or above the selected length
   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mask
         assign payload[i] = data[i] & (32'(i) < txf_bits(wlen));
      end
   endgenerate

   assign parity = (^payload) ^ par_odd;

endmodule

// File: rtl/uart_txf_bitclk.sv
module uart_txf_bitclk #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic [CW-1:0] len,
   output logic          bit_end
);

   logic [CW-1:0] cnt_q;
   logic          at_last;

   assign at_last = (cnt_q == len - CW'(1));
   assign bit_end = run && tick && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run || bit_end)  cnt_q <= '0;
      else if (tick)             cnt_q <= cnt_q + CW'(1);
   end

endmodule

// File: rtl/uart_txf_seq.sv
module uart_txf_seq
   import uart_txf_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16,
   parameter int CW         = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] payload,
   input  logic              parity,
   input  logic [1:0]        wlen,
   input  logic              par_en,
   input  logic              stop_long,
   input  logic              bit_end,
   output txf_state_e        state,
   output logic              line_bit,
   output logic [CW-1:0]     bit_len
);

   localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CW-1:0] LEN_ONE   = CW'(OVERSAMPLE);
   localparam logic [CW-1:0] LEN_THREE = CW'(OVERSAMPLE * 3 / 2);
   localparam logic [CW-1:0] LEN_TWO   = CW'(OVERSAMPLE * 2);

   txf_state_e        state_q;
   logic [DATA_W-1:0] shreg_q;
   logic [BW-1:0]     left_q;
   logic              par_q;
   logic [1:0]        wlen_q;
   logic              pe_q;
   logic              sl_q;

   // length of the current bit in ticks
   always_comb begin
      bit_len = LEN_ONE;
      if (state_q == ST_STOP && sl_q)
         bit_len = (wlen_q == 2'd0) ? LEN_THREE : LEN_TWO;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         shreg_q <= '0;
         left_q  <= '0;
         par_q   <= 1'b0;
         wlen_q  <= 2'd0;
         pe_q    <= 1'b0;
         sl_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_START;
                  shreg_q <= payload;
                  par_q   <= parity;
                  wlen_q  <= wlen;
                  pe_q    <= par_en;
                  sl_q    <= stop_long;
                  left_q  <= BW'(txf_bits(wlen) - 32'd1);
               end
            end
            ST_START: if (bit_end) state_q <= ST_DATA;
            ST_DATA: begin
               if (bit_end) begin
                  if (left_q == '0) begin
                     state_q <= pe_q ? ST_PAR : ST_STOP;
                  end else begin
                     left_q  <= left_q - BW'(1);
                     shreg_q <= shreg_q >> 1;
                  end
               end
            end
            ST_PAR:  if (bit_end) state_q <= ST_STOP;
            ST_STOP: if (bit_end) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state_q)
         ST_START: line_bit = 1'b0;
         ST_DATA:  line_bit = shreg_q[0];
         ST_PAR:   line_bit = par_q;
         default:  line_bit = 1'b1;
      endcase
   end

   assign state = state_q;

endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
   import uart_txf_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic [DATA_W-1:0] chr_data,
   input  logic              chr_valid,
   input  logic [1:0]        cfg_wlen,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_stop_long,
   input  logic              cfg_break,
   input  logic              cfg_flow_en,
   input  logic              cts,
   output logic              tx_ready,
   output logic              tx_empty,
   output logic              txd
);

   localparam int CW = $clog2(2 * OVERSAMPLE + 1);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("uart_tx_flow: DATA_W must be at least 8");
      end
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("uart_tx_flow: OVERSAMPLE must be even and at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("uart_tx_flow: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic              cts_s;
   logic [DATA_W-1:0] payload;
   logic              parity;
   logic              bit_end;
   logic [CW-1:0]     bit_len;
   logic              line_bit;
   txf_state_e        state;
   logic              accept;
   logic              idle;

   uart_txf_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (cts),
      .sync_out (cts_s)
   );

   uart_txf_framer #(.DATA_W(DATA_W)) u_frm (
      .data    (chr_data),
      .wlen    (cfg_wlen),
      .par_odd (cfg_par_odd),
      .payload (payload),
      .parity  (parity)
   );

   uart_txf_bitclk #(.CW(CW)) u_bclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (!idle),
      .tick    (tick16),
      .len     (bit_len),
      .bit_end (bit_end)
   );

   uart_txf_seq #(
      .DATA_W     (DATA_W),
      .OVERSAMPLE (OVERSAMPLE),
      .CW         (CW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .payload   (payload),
      .parity    (parity),
      .wlen      (cfg_wlen),
      .par_en    (cfg_par_en),
      .stop_long (cfg_stop_long),
      .bit_end   (bit_end),
      .state     (state),
      .line_bit  (line_bit),
      .bit_len   (bit_len)
   );

   assign idle     = (state == ST_IDLE);
   assign tx_ready = idle && (!cfg_flow_en || cts_s);
   assign accept   = chr_valid && tx_ready;
   assign tx_empty = idle;
   assign txd      = cfg_break ? 1'b0 : line_bit;

endmodule

module uart_tx_flow_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic tick16,
   input logic chr_valid,
   input logic cfg_break,
   input logic cfg_flow_en,
   input logic cts,
   input logic tx_ready,
   input logic tx_empty,
   input logic txd
);

   // own record of recent cts samples
   logic [SYNC_STAGES:0] hist_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q[0] <= 1'b0;
      else        hist_q[0] <= cts;
   end
   generate
      for (genvar k = 1; k <= SYNC_STAGES; k++) begin : g_hist
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q[k] <= 1'b0;
            else        hist_q[k] <= hist_q[k-1];
         end
      end
   endgenerate

   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty && !cfg_break |-> txd);

   a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      chr_valid && tx_ready |=> !tx_empty && !tx_ready);

   a_r2_leave_idle_by_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_empty) |-> $past(chr_valid && tx_ready));

   a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      chr_valid && tx_ready |=> (cfg_break || !txd));

   a_r7_break_low: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_break |-> !txd);

   a_r8_cts_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_flow_en && !cts && (hist_q == '0) |-> !tx_ready);

   a_r10_no_tick_no_end: assert property (@(posedge clk) disable iff (!rst_n)
      !tick16 && !(chr_valid && tx_ready) |=> tx_empty == $past(tx_empty));

endmodule

bind uart_tx_flow uart_tx_flow_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick16      (tick16),
   .chr_valid   (chr_valid),
   .cfg_break   (cfg_break),
   .cfg_flow_en (cfg_flow_en),
   .cts         (cts),
   .tx_ready    (tx_ready),
   .tx_empty    (tx_empty),
   .txd         (txd)
);

// File: tb/uart_tx_flow_test.sv
module uart_tx_flow_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic [7:0] chr_data = '0;
   logic       chr_valid = 1'b0;
   logic [1:0] cfg_wlen = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       cfg_stop_long = 1'b0;
   logic       cfg_break = 1'b0;
   logic       cfg_flow_en = 1'b0;
   logic       cts = 1'b1;
   logic       tx_ready, tx_empty, txd;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;

   always #4 clk = ~clk;

   uart_tx_flow uut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .chr_data(chr_data),
      .chr_valid(chr_valid), .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
      .cfg_par_odd(cfg_par_odd), .cfg_stop_long(cfg_stop_long),
      .cfg_break(cfg_break), .cfg_flow_en(cfg_flow_en), .cts(cts),
      .tx_ready(tx_ready), .tx_empty(tx_empty), .txd(txd)
   );

   function automatic int frame_ticks(int wl, bit pe, bit sl);
      int nb = 5 + wl;
      int st = sl ? ((nb == 5) ? 24 : 32) : 16;
      return 16 + 16 * nb + (pe ? 16 : 0) + st;
   endfunction

   function automatic logic exp_level(int t, logic [7:0] d, int wl, bit pe, bit po);
      int   nb = 5 + wl;
      logic p  = po;
      for (int i = 0; i < nb; i++) p ^= d[i];
      if (t < 16) return 1'b0;
      t -= 16;
      if (t < 16 * nb) return d[t / 16];
      t -= 16 * nb;
      if (pe && t < 16) return p;
      return 1'b1;
   endfunction

   function automatic string seg_tag(int t, int wl, bit pe);
      int nb = 5 + wl;
      if (t < 16) return "R3";
      if (t < 16 + 16 * nb) return "R4";
      if (pe && t < 32 + 16 * nb) return "R5";
      return "R6";
   endfunction

   task automatic chk(string req, logic act, logic exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic send_frame(logic [7:0] d, int wl, bit pe, bit po, bit sl,
                             bit brk, int drop_at, int gapmax);
      int   n;
      logic e;
      logic v;
      string tag;
      cfg_wlen = 2'(wl); cfg_par_en = pe; cfg_par_odd = po;
      cfg_stop_long = sl; cfg_break = brk;
      @(negedge clk);
      chk("R2", tx_ready, 1'b1, "ready before offer");
      chr_data = d; chr_valid = 1'b1;
      @(negedge clk);
      chr_valid = 1'b0; chr_data = 8'($urandom);
      // settings changed after acceptance must not matter (R2)
      cfg_wlen = 2'($urandom); cfg_par_en = 1'($urandom);
      cfg_par_odd = 1'($urandom); cfg_stop_long = 1'($urandom);
      chk("R2", tx_empty, 1'b0, "busy after accept");
      chk("R2", tx_ready, 1'b0, "not ready while busy");
      n = frame_ticks(wl, pe, sl);
      for (int t = 0; t < n; t++) begin
         int gap;
         e   = brk ? 1'b0 : exp_level(t, d, wl, pe, po);
         tag = brk ? "R7" : (drop_at >= 0 ? "R9" : seg_tag(t, wl, pe));
         chk(tag, txd, e, "line level");
         if (t == n - 1) chk("R6", tx_empty, 1'b0, "busy before last tick");
         if (t == drop_at) cts = 1'b0;
         gap = $urandom_range(0, gapmax);
         tick16 = 1'b1;
         @(negedge clk);
         tick16 = 1'b0;
         if (gap > 0) begin
            v = txd;
            repeat (gap) @(negedge clk);
            chk("R10", txd, v, "stable between ticks");
         end
      end
      chk("R6", tx_empty, 1'b1, "empty at frame end");
      chk(brk ? "R7" : "R6", txd, brk ? 1'b0 : 1'b1, "level after frame");
   endtask

   task automatic tick_once();
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", txd, 1'b1, "reset line level");
      chk("R1", tx_empty, 1'b1, "reset empty");
      chk("R1", tx_ready, 1'b1, "reset ready");

      // directed framing corners
      send_frame(8'hA5, 3, 0, 0, 0, 0, -1, 0);
      send_frame(8'hF3, 0, 0, 0, 1, 0, -1, 1);   // 5 bits, 24-tick stop, upper bits ignored
      send_frame(8'h2D, 1, 1, 0, 0, 0, -1, 0);   // even parity
      send_frame(8'h51, 2, 1, 1, 1, 0, -1, 2);   // odd parity, 32-tick stop
      send_frame(8'h00, 3, 1, 1, 1, 0, -1, 0);

      // break during a frame, then while idle
      send_frame(8'hFF, 3, 1, 0, 0, 1, -1, 1);
      cfg_break = 1'b0;
      @(negedge clk);
      chk("R7", txd, 1'b1, "line released after break");
      cfg_break = 1'b1;
      @(negedge clk);
      chk("R7", txd, 1'b0, "break while idle");
      cfg_break = 1'b0;
      @(negedge clk);

      // flow control off: cts ignored
      cfg_flow_en = 1'b0; cts = 1'b0;
      repeat (4) @(negedge clk);
      chk("R8", tx_ready, 1'b1, "cts ignored when flow off");
      send_frame(8'h3C, 3, 0, 0, 0, 0, -1, 0);

      // flow control on with cts low: hold off
      cfg_flow_en = 1'b1;
      @(negedge clk);
      chk("R8", tx_ready, 1'b0, "held by cts");
      chr_data = 8'h99; chr_valid = 1'b1;
      repeat (20) tick_once();
      chk("R8", tx_empty, 1'b1, "no start while held");
      chk("R8", txd, 1'b1, "line idle while held");
      chr_valid = 1'b0;
      cts = 1'b1;
      @(negedge clk);
      chk("R8", tx_ready, 1'b0, "cts still in synchroniser");
      @(negedge clk);
      chk("R8", tx_ready, 1'b1, "ready after sync latency");

      // cts drops partway through a frame
      send_frame(8'hC6, 3, 1, 0, 1, 0, 40, 1);
      repeat (3) @(negedge clk);
      chk("R9", tx_ready, 1'b0, "next start held after drop");
      cts = 1'b1;
      repeat (3) @(negedge clk);

      // random frames
      for (int k = 0; k < 40; k++) begin
         cfg_flow_en = 1'($urandom);
         send_frame(8'($urandom), int'($urandom_range(0, 3)), 1'($urandom),
                    1'($urandom), 1'($urandom), 0, -1, 2);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule